// File: doc/BRIEF.md
# Ethernet Transmit Abort Terminator

This block sits in a MAC transmit path, between a byte-wide frame source and the serializer that drives the line. It passes frame bytes through while keeping two pieces of frame state: a saturating count of the bits already handed to the line, and a running CRC-32 over those bytes. When a frame's last byte has gone out, it appends the frame check sequence as four bytes.

An abort request can arrive while a frame is in flight. The block then picks one of two endings. If the frame is still shorter than the minimum length, it stops at once and leaves a runt, with no check sequence. Once the frame has reached the minimum length, it lets the byte already handed to the serializer finish and then, starting at the next byte boundary, sends the bitwise inverse of the normal check sequence. This guarantees that the receiver sees a check-sequence error. In both cases the rest of the aborted frame is taken from the source and dropped. A one-cycle done pulse reports how each frame ended.

The byte offered on the cycle the abort is sampled counts as not yet started. Only bytes already accepted by the serializer are "under way", and the serializer completes them on its own.

Top module: `tx_abort_term`

## Requirements
- R1: During the data phase, `line_data`/`line_valid` follow `src_data`/`src_valid`, and `src_ready` equals `line_ready` on every cycle without a sampled abort.
- R2: After the byte flagged by `src_last` is accepted, the block sends four FCS bytes, least significant byte first. The FCS is the complement of a reflected CRC-32 (polynomial 0x04C11DB7, register seeded with all ones) over the frame bytes. The nine ASCII bytes "123456789" give the line bytes 0x26, 0x39, 0xF4, 0xCB.
- R3: An abort sampled while fewer than MIN_BITS (512) bits of the frame have been accepted blocks the byte offered in that cycle and sends nothing more of the frame. The next cycle, `done` pulses with `done_kind` = 2'b10 (runt).
- R4: An abort sampled at MIN_BITS or more blocks the byte offered in that cycle, then sends four bytes that are the bitwise inverse of the R2 FCS over the bytes accepted so far, least significant byte first. After the fourth byte, `done` pulses with `done_kind` = 2'b11.
- R5: Every byte accepted before the abort cycle appears on the line unchanged and in order, whichever way the frame ends.
- R6: After an abort, `src_ready` stays high and source bytes up to and including `src_last` are dropped. The next frame starts with a fresh CRC and bit count, so its FCS is correct.
- R7: An abort during a normal FCS transfer is ignored: the FCS bytes are unchanged and `done_kind` is 2'b01.
- R8: An abort sampled before the first byte of a frame is accepted is ignored, and that frame ends normally.
- R9: While `line_ready` is low during an FCS transfer, `line_valid` stays high and `line_data` holds its value.
- R10: `done` is high for exactly one cycle per frame. It is 2'b01 for a normal end, and `done_kind` is 2'b00 whenever `done` is low.
- R11: During and right after reset, `done` is low, `done_kind` is 2'b00 and `line_valid` is low, and the block is ready for the first byte of a frame.
- R12: The threshold is exact. An abort after 63 accepted bytes gives a runt, and an abort after 64 accepted bytes gives the inverted FCS. The bit count saturates once it reaches MIN_BITS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_data | input | 8 | Frame byte from the source |
| src_valid | input | 1 | Source byte is valid |
| src_last | input | 1 | Source byte is the last of the frame |
| src_ready | output | 1 | Source byte is accepted this cycle |
| line_ready | input | 1 | Serializer takes a byte this cycle |
| abort_req | input | 1 | Request to end the current frame early |
| line_data | output | 8 | Byte toward the serializer |
| line_valid | output | 1 | `line_data` is valid |
| done | output | 1 | One-cycle pulse when a frame ends |
| done_kind | output | 2 | End type: 01 normal, 10 runt, 11 inverted FCS, 00 idle |

## Verification
A corrupted CRC register does not show at the ports until the frame's check-sequence bytes appear, four to several hundred cycles later. The bench therefore compares every FCS byte against its own CRC model, including the known-answer frame. A miscounted bit meter only shows when an abort lands near the threshold, so aborts after 63 and after 64 bytes are both applied and the resulting end type is checked. A wrong state shows within one cycle as extra or missing line bytes or a misplaced done pulse, so each frame's complete line output and done history is compared.

// File: rtl/tx_abort_pkg.sv
package tx_abort_pkg;

   localparam int          CRC_W         = 32;
   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
   localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;

   typedef enum logic [1:0] {
      END_NONE   = 2'b00,
      END_NORMAL = 2'b01,
      END_RUNT   = 2'b10,
      END_BADFCS = 2'b11
   } end_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DATA,
      ST_FCS_OK,
      ST_FCS_BAD,
      ST_DRAIN
   } tx_state_e;

endpackage

// File: rtl/tx_crc32_acc.sv
module tx_crc32_acc
   import tx_abort_pkg::*;
#(
   parameter int          BYTE_W = 8,
   parameter logic [31:0] POLY   = CRC_POLY_REFL,
   parameter logic [31:0] SEED   = CRC_SEED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              upd,
   input  logic [BYTE_W-1:0] din,
   output logic [CRC_W-1:0]  crc
);

   if (BYTE_W < 1) begin : g_bad_width
      $error("tx_crc32_acc: BYTE_W must be positive");
   end

   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] stage [0:BYTE_W];

   assign stage[0] = crc_q;

   // one unrolled shift stage per input bit, LSB first
   for (genvar g = 0; g < BYTE_W; g++) begin : g_bit
      assign stage[g+1] = (stage[g][0] ^ din[g]) ? ((stage[g] >> 1) ^ POLY)
                                                  :  (stage[g] >> 1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      crc_q <= SEED;
      else if (clear)  crc_q <= SEED;
      else if (upd)    crc_q <= stage[BYTE_W];
   end

   assign crc = crc_q;

   // R6: a cleared accumulator starts the next frame from the seed
   a_r6_crc_reseed: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (crc == SEED));

endmodule

// File: rtl/tx_bit_meter.sv
module tx_bit_meter #(
   parameter int MIN_BITS = 512,
   parameter int BYTE_W   = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic past_min
);

   localparam int MIN_BYTES = MIN_BITS / BYTE_W;
   localparam int CNT_W     = $clog2(MIN_BYTES + 1);

   if (MIN_BITS <= 0 || (MIN_BITS % BYTE_W) != 0) begin : g_bad_min
      $error("tx_bit_meter: MIN_BITS must be a positive multiple of BYTE_W");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             sat;

   assign sat = (cnt_q == CNT_W'(MIN_BYTES));

   always_ff @(posedge clk) begin
      if (!rst_n)               cnt_q <= '0;
      else if (clear)           cnt_q <= '0;
      else if (step && !sat)    cnt_q <= cnt_q + CNT_W'(1);
   end

   assign past_min = sat;

   // R12: byte count never passes the saturation point
   a_r12_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(MIN_BYTES));

   // R12: each accepted byte below the threshold advances the count by one
   a_r12_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clear && !sat) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/tx_fcs_sel.sv
module tx_fcs_sel #(
   parameter int BYTE_W = 8,
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0]                   crc,
   input  logic                                normal,
   input  logic [$clog2(WORD_W/BYTE_W)-1:0]    idx,
   output logic [BYTE_W-1:0]                   byte_out
);

   localparam int NLANES = WORD_W / BYTE_W;

   if ((WORD_W % BYTE_W) != 0 || NLANES < 2) begin : g_bad_split
      $error("tx_fcs_sel: WORD_W must split into at least two lanes");
   end

   logic [WORD_W-1:0] word;
   logic [BYTE_W-1:0] lanes [NLANES];

   // normal end sends the complement; abort end sends the raw register
   assign word = normal ? ~crc : crc;

   for (genvar g = 0; g < NLANES; g++) begin : g_lane
      assign lanes[g] = word[g*BYTE_W +: BYTE_W];
   end

   assign byte_out = lanes[idx];

endmodule

// File: rtl/tx_abort_term.sv
module tx_abort_term
   import tx_abort_pkg::*;
#(
   parameter int MIN_BITS = 512,
   parameter int BYTE_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] src_data,
   input  logic              src_valid,
   input  logic              src_last,
   output logic              src_ready,
   input  logic              line_ready,
   input  logic              abort_req,
   output logic [BYTE_W-1:0] line_data,
   output logic              line_valid,
   output logic              done,
   output logic [1:0]        done_kind
);

   localparam int FCS_BYTES = CRC_W / BYTE_W;
   localparam int IDX_W     = $clog2(FCS_BYTES);

   if (BYTE_W != 8) begin : g_bad_byte
      $error("tx_abort_term: line is byte-wide, BYTE_W must be 8");
   end

   tx_state_e        st_q;
   logic [IDX_W-1:0] fcs_idx_q;
   logic             done_q;
   end_kind_e        kind_q;

   logic             data_phase, in_fcs, abort_hit;
   logic             data_xfer, fcs_xfer, fcs_last, runt_cut, close;
   logic             past_min;
   logic [CRC_W-1:0] crc;
   logic [BYTE_W-1:0] fcs_byte;

   assign data_phase = (st_q == ST_IDLE) || (st_q == ST_DATA);
   assign in_fcs     = (st_q == ST_FCS_OK) || (st_q == ST_FCS_BAD);
   assign abort_hit  = abort_req && (st_q == ST_DATA);
   assign data_xfer  = data_phase && src_valid && line_ready && !abort_hit;
   assign fcs_xfer   = in_fcs && line_ready;
   assign fcs_last   = fcs_xfer && (fcs_idx_q == IDX_W'(FCS_BYTES - 1));
   assign runt_cut   = abort_hit && !past_min;
   assign close      = runt_cut || fcs_last;

   tx_crc32_acc #(.BYTE_W(BYTE_W)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (close),
      .upd   (data_xfer),
      .din   (src_data),
      .crc   (crc)
   );

   tx_bit_meter #(.MIN_BITS(MIN_BITS), .BYTE_W(BYTE_W)) u_meter (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (close),
      .step     (data_xfer),
      .past_min (past_min)
   );

   tx_fcs_sel #(.BYTE_W(BYTE_W), .WORD_W(CRC_W)) u_fcs (
      .crc      (crc),
      .normal   (st_q == ST_FCS_OK),
      .idx      (fcs_idx_q),
      .byte_out (fcs_byte)
   );

   always_comb begin
      line_valid = 1'b0;
      line_data  = src_data;
      src_ready  = 1'b0;
      if (data_phase) begin
         line_valid = src_valid && !abort_hit;
         src_ready  = line_ready && !abort_hit;
      end else if (in_fcs) begin
         line_valid = 1'b1;
         line_data  = fcs_byte;
      end else begin
         src_ready  = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         fcs_idx_q <= '0;
         done_q    <= 1'b0;
         kind_q    <= END_NONE;
      end else begin
         done_q <= 1'b0;
         kind_q <= END_NONE;
         unique case (st_q)
            ST_IDLE, ST_DATA: begin
               if (abort_hit) begin
                  fcs_idx_q <= '0;
                  if (past_min) begin
                     st_q <= ST_FCS_BAD;
                  end else begin
                     st_q   <= ST_DRAIN;
                     done_q <= 1'b1;
                     kind_q <= END_RUNT;
                  end
               end else if (data_xfer) begin
                  fcs_idx_q <= '0;
                  st_q      <= src_last ? ST_FCS_OK : ST_DATA;
               end
            end
            ST_FCS_OK, ST_FCS_BAD: begin
               if (fcs_xfer) begin
                  fcs_idx_q <= fcs_idx_q + IDX_W'(1);
                  if (fcs_last) begin
                     done_q <= 1'b1;
                     kind_q <= (st_q == ST_FCS_OK) ? END_NORMAL : END_BADFCS;
                     st_q   <= (st_q == ST_FCS_OK) ? ST_IDLE : ST_DRAIN;
                  end
               end
            end
            ST_DRAIN: begin
               if (src_valid && src_last) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign done      = done_q;
   assign done_kind = kind_q;

   // R3: the cycle reporting a runt sends nothing on the line
   a_r3_runt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_kind == END_RUNT) |-> !line_valid);

   // R10: done never lasts two cycles
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: a stalled FCS byte stays on the line unchanged
   a_r9_fcs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (in_fcs && !line_ready) |=> (line_valid && $stable(line_data)));

   // R7: an abort during a normal FCS leaves the normal FCS running
   a_r7_fcs_abort_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FCS_OK && abort_req && !line_ready) |=> (st_q == ST_FCS_OK));

endmodule

// File: tb/tx_abort_term_tb.sv
`timescale 1ns/1ps
module tx_abort_term_tb;

   localparam int MIN_BITS = 512;
   localparam int NVEC     = 10;

   // columns: length, abort after N bytes (0 none), abort in FCS, stall, abort before first byte, seed
   localparam int VEC [NVEC][6] = '{
      '{  9,  0, 0, 0, 0,  0 },
      '{ 20,  0, 0, 1, 0,  3 },
      '{ 70, 10, 0, 0, 0,  5 },
      '{ 70, 63, 0, 0, 0,  7 },
      '{ 70, 64, 0, 0, 0,  9 },
      '{100, 80, 0, 1, 0, 11 },
      '{ 30,  0, 1, 1, 0, 13 },
      '{ 12,  0, 0, 0, 1, 17 },
      '{ 64,  0, 0, 0, 0, 19 },
      '{ 65, 64, 0, 0, 0, 23 }
   };

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] src_data;
   logic       src_valid, src_last, src_ready;
   logic       line_ready, abort_req;
   logic [7:0] line_data;
   logic       line_valid, done;
   logic [1:0] done_kind;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc_total = 0;
   logic [7:0] got [$];

   always #2 clk = ~clk;

   tx_abort_term #(.MIN_BITS(MIN_BITS), .BYTE_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .src_data(src_data), .src_valid(src_valid), .src_last(src_last),
      .src_ready(src_ready), .line_ready(line_ready), .abort_req(abort_req),
      .line_data(line_data), .line_valid(line_valid),
      .done(done), .done_kind(done_kind)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r = c;
      for (int b = 0; b < 8; b++) begin
         if ((r[0] ^ d[b]) == 1'b1) r = (r >> 1) ^ 32'hEDB88320;
         else                       r = r >> 1;
      end
      return r;
   endfunction

   function automatic logic [7:0] src_byte(input int seed, input int i);
      if (seed == 0) return 8'(8'h31 + i);
      return 8'(i * 37 + seed * 11 + (i >> 3));
   endfunction

   always @(posedge clk) begin
      cyc_total++;
      if (cyc_total > 150000) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc_total, 150000);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic run_frame(input int v);
      int len      = VEC[v][0];
      int abort_at = VEC[v][1];
      bit fcs_ab   = VEC[v][2] != 0;
      bit stall    = VEC[v][3] != 0;
      bit idle_ab  = VEC[v][4] != 0;
      int seed     = VEC[v][5];
      int i = 0, dones = 0, kind = 0, ready_bad = 0, kind_bad = 0, after = 0;
      int nsent, exp_kind, mism;
      bit aborted = 0, fcs_ab_done = 0, finished = 0, runt;
      logic [31:0] c;
      logic [7:0]  exp_q [$];

      got.delete();
      for (int k = 0; k < 3000 && !finished; k++) begin
         @(negedge clk);
         line_ready = (stall && (k % 2 == 1)) ? 1'b0 : 1'b1;
         abort_req  = 1'b0;
         if (i < len) begin
            src_valid = 1'b1;
            src_data  = src_byte(seed, i);
            src_last  = (i == len - 1);
         end else begin
            src_valid = 1'b0;
            src_data  = 8'h00;
            src_last  = 1'b0;
         end
         if (abort_at > 0 && !aborted && i == abort_at) begin
            abort_req = 1'b1;
            aborted   = 1'b1;
         end
         if (fcs_ab && !fcs_ab_done && i == len) begin
            abort_req   = 1'b1;
            fcs_ab_done = 1'b1;
         end
         if (idle_ab && k == 0) abort_req = 1'b1;
         #1;
         if (done) begin
            dones++;
            kind = done_kind;
         end else if (done_kind != 2'b00) begin
            kind_bad++;
         end
         if (i < len && !aborted && !abort_req && src_ready !== line_ready) ready_bad++;
         if (line_valid && line_ready) got.push_back(line_data);
         if (src_valid && src_ready) i++;
         if (i == len && dones > 0) after++;
         if (after > 6) finished = 1;
      end
      abort_req = 1'b0;
      src_valid = 1'b0;
      src_last  = 1'b0;

      chk(finished, "R6", $sformatf("vec %0d frame completion", v), finished, 1);

      nsent = (abort_at == 0) ? len : abort_at;
      runt  = (abort_at > 0) && (abort_at * 8 < MIN_BITS);
      c = 32'hFFFF_FFFF;
      for (int j = 0; j < nsent; j++) begin
         exp_q.push_back(src_byte(seed, j));
         c = crc_step(c, src_byte(seed, j));
      end
      if (!runt) begin
         if (abort_at == 0) c = ~c;
         for (int j = 0; j < 4; j++) exp_q.push_back(c[8*j +: 8]);
      end
      exp_kind = (abort_at == 0) ? 1 : (runt ? 2 : 3);

      // R5 / R2 / R4 / R3: complete line output of the frame
      chk(got.size() == exp_q.size(), "R5", $sformatf("vec %0d line byte count", v),
          got.size(), exp_q.size());
      mism = -1;
      for (int j = 0; j < exp_q.size() && j < got.size(); j++)
         if (mism < 0 && got[j] !== exp_q[j]) mism = j;
      if (mism < 0)
         chk(1'b1, "R4", $sformatf("vec %0d line bytes", v), 0, 0);
      else
         chk(1'b0, runt ? "R3" : (abort_at > 0 ? "R4" : "R2"),
             $sformatf("vec %0d line byte %0d", v, mism), got[mism], exp_q[mism]);

      // R12 / R7 / R8: end type
      chk(kind == exp_kind, (abort_at == 63 || abort_at == 64) ? "R12" :
          (fcs_ab ? "R7" : (idle_ab ? "R8" : "R3")),
          $sformatf("vec %0d end type", v), kind, exp_kind);
      chk(dones == 1, "R10", $sformatf("vec %0d done pulses", v), dones, 1);
      chk(kind_bad == 0, "R10", $sformatf("vec %0d kind while idle", v), kind_bad, 0);
      chk(ready_bad == 0, "R1", $sformatf("vec %0d src_ready tracking", v), ready_bad, 0);
   endtask

   initial begin
      rst_n      = 1'b0;
      src_data   = 8'h00;
      src_valid  = 1'b0;
      src_last   = 1'b0;
      line_ready = 1'b1;
      abort_req  = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk(!done && !line_valid && done_kind == 2'b00, "R11", "outputs in reset",
          {done, line_valid, done_kind}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(!done && !line_valid && done_kind == 2'b00, "R11", "outputs after reset",
          {done, line_valid, done_kind}, 0);
      chk(src_ready == 1'b1, "R11", "ready for first byte", src_ready, 1);

      for (int v = 0; v < NVEC; v++) begin
         run_frame(v);
         if (v == 0) begin
            // R2: known answer for "123456789"
            chk(got.size() == 13, "R2", "known-answer length", got.size(), 13);
            if (got.size() == 13)
               chk({got[12], got[11], got[10], got[9]} == 32'hCBF43926, "R2",
                   "known-answer FCS", {got[12], got[11], got[10], got[9]}, 32'hCBF43926);
         end
      end

      // R6: a second clean frame straight after an aborted one
      run_frame(4);
      run_frame(0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule